// File: doc/BRIEF.md
# Bit-Selectable-Reset PWM Generator

This block produces one pulse-width-modulated output from a single free-running counter that advances on a slow tick strobe, nominally 32 kHz. A small prescaler field picks which bit of the counter clears it. That fixes the period at 128, 64, 32 or 16 ticks, which is 4 ms, 2 ms, 1 ms or 0.5 ms at the nominal tick rate. A higher frequency leaves fewer counter bits for duty resolution. The output is high while the counter sits below a 7-bit duty value.

A byte-wide register port holds two registers. The control register is at offset 0, with the enable in bit 7 and the prescaler in bits 1:0. The duty register is at offset 1 and holds a 7-bit high time in ticks. Writes take effect at once. A new duty value applies at the next comparison. A prescaler change leaves the counter alone, so the period that is running can be cut short or stretched.

Top module: `bitsel_pwm`

## Requirements
- R1: After reset both registers read 0x00 and `pwm_o` is low.
- R2: With the block enabled at prescaler p, the counter clears on the tick that would set its bit 7−p. The period is therefore 128, 64, 32 or 16 ticks for p = 0, 1, 2, 3.
- R3: While enabled, `pwm_o` is high exactly while the counter value is below the duty value.
- R4: A duty value of 0 holds `pwm_o` low for every tick.
- R5: At prescaler 0, duty 127 gives 127 high ticks and exactly one low tick in each 128-tick period, so full duty cannot be reached.
- R6: At prescaler 1, 2 or 3, a duty value at or above the period length holds `pwm_o` high for the whole period.
- R7: While the enable bit is 0, the counter is held at zero and `pwm_o` is low, whatever the duty value. When the block is enabled again, counting starts from zero.
- R8: A write to the duty register changes `pwm_o` one clock after the write edge, including in the middle of a period.
- R9: A prescaler change while enabled does not clear the counter. The counter keeps counting until the newly selected bit would become 1.
- R10: Control bits 6:2 and duty bit 7 ignore writes and read back as zero. Writing 0xFF reads back 0x83 from offset 0 and 0x7F from offset 1. Registers can be written while the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Counter advance strobe, one clock wide |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register offset: 0 control, 1 duty |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for `addr_i`, combinational |
| pwm_o | output | 1 | Registered PWM output |

## Verification
Read data follows the register contents, so it shows a write in the clock after the write edge. The counter moves on the edge that samples a tick, and `pwm_o` follows one edge later. Each tick's result is therefore due two edges after the strobe is raised. A duty or enable write shows at the output one edge after the write edge. The bench raises every stimulus at a falling edge and samples the output at the falling edge after the due edge. A tick-level reference model pushes one expected output level per tick into the scoreboard queue before that tick is driven.

// File: rtl/bitsel_pwm_pkg.sv
package bitsel_pwm_pkg;
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_DUTY = 1;

  typedef struct packed {
    logic       en;
    logic [1:0] psc;
  } ctrl_view_t;
endpackage

// File: rtl/bitsel_pwm_rst_sync.sv
module bitsel_pwm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/bitsel_pwm_regs.sv
module bitsel_pwm_regs
  import bitsel_pwm_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PSC_W  = 2,
  parameter int unsigned DUTY_W = 7,
  parameter int unsigned ADDR_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              en_o,
  output logic [PSC_W-1:0]  psc_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(OFS_DUTY);

  logic              en_q,   en_d;
  logic [PSC_W-1:0]  psc_q,  psc_d;
  logic [DUTY_W-1:0] duty_q, duty_d;
  logic              ctrl_we, duty_we;

  assign ctrl_we = wr_en_i && (addr_i == A_CTRL);
  assign duty_we = wr_en_i && (addr_i == A_DUTY);

  always_comb begin
    en_d   = en_q;
    psc_d  = psc_q;
    duty_d = duty_q;
    if (ctrl_we) begin
      en_d  = wr_data_i[DATA_W-1];
      psc_d = wr_data_i[PSC_W-1:0];
    end
    if (duty_we) duty_d = wr_data_i[DUTY_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      psc_q  <= '0;
      duty_q <= '0;
    end else begin
      en_q   <= en_d;
      psc_q  <= psc_d;
      duty_q <= duty_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (addr_i == A_CTRL) begin
      rd_data_o[DATA_W-1]  = en_q;
      rd_data_o[PSC_W-1:0] = psc_q;
    end else if (addr_i == A_DUTY) begin
      rd_data_o[DUTY_W-1:0] = duty_q;
    end
  end

  assign en_o   = en_q;
  assign psc_o  = psc_q;
  assign duty_o = duty_q;
endmodule

// File: rtl/bitsel_pwm_counter.sv
module bitsel_pwm_counter #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PSC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned NUM_PSC = 2 ** PSC_W;

  logic [CNT_W-1:0]   cnt_q, cnt_d, cnt_inc;
  logic [NUM_PSC-1:0] clr_hit;

  assign cnt_inc = cnt_q + CNT_W'(1);

  // one candidate clear bit per prescaler setting, top bit downward
  for (genvar g = 0; g < NUM_PSC; g++) begin : g_clr
    assign clr_hit[g] = cnt_inc[CNT_W-1-g];
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = clr_hit[psc_i] ? '0 : cnt_inc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/bitsel_pwm_compare.sv
module bitsel_pwm_compare #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DUTY_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);
  logic pwm_q, pwm_d;

  always_comb pwm_d = en_i && (cnt_i < CNT_W'(duty_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= pwm_d;
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/bitsel_pwm.sv
module bitsel_pwm #(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned PSC_W      = 2,
  parameter int unsigned ADDR_W     = 1,
  parameter int unsigned SYNC_STAGE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic              pwm_o
);
  localparam int unsigned DATA_W = CNT_W;
  localparam int unsigned DUTY_W = CNT_W - 1;

  logic              rst_n_sync;
  logic              ctrl_en;
  logic [PSC_W-1:0]  psc_val;
  logic [DUTY_W-1:0] duty_val;
  logic [CNT_W-1:0]  cnt_val;

  bitsel_pwm_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_sync)
  );

  bitsel_pwm_regs #(
    .DATA_W(DATA_W), .PSC_W(PSC_W), .DUTY_W(DUTY_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_sync),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wr_data_i(wr_data_i),
    .en_o     (ctrl_en),
    .psc_o    (psc_val),
    .duty_o   (duty_val),
    .rd_data_o(rd_data_o)
  );

  bitsel_pwm_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_n_sync),
    .tick_i(tick_i),
    .en_i  (ctrl_en),
    .psc_i (psc_val),
    .cnt_o (cnt_val)
  );

  bitsel_pwm_compare #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_cmp (
    .clk_i (clk_i),
    .rst_ni(rst_n_sync),
    .en_i  (ctrl_en),
    .cnt_i (cnt_val),
    .duty_i(duty_val),
    .pwm_o (pwm_o)
  );
endmodule

// File: rtl/bitsel_pwm_chk.sv
module bitsel_pwm_chk #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DUTY_W = 7
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              tick_i,
  input logic              en,
  input logic [CNT_W-1:0]  cnt,
  input logic [DUTY_W-1:0] duty,
  input logic              pwm
);
  p_off_low_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en |=> !pwm);

  p_cnt_held_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en |=> (cnt == '0));

  p_cnt_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en && !tick_i) |=> $stable(cnt));

  p_zero_duty_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (duty == '0) |=> !pwm);

  p_high_below_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en && (cnt < CNT_W'(duty))) |=> pwm);
endmodule

bind bitsel_pwm bitsel_pwm_chk #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_chk (
  .clk_i (clk_i),
  .rst_n (rst_n_sync),
  .tick_i(tick_i),
  .en    (ctrl_en),
  .cnt   (cnt_val),
  .duty  (duty_val),
  .pwm   (pwm_o)
);

// File: tb/bitsel_pwm_tb_top.sv
`timescale 1ns/1ps
module bitsel_pwm_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       wr_en;
  logic [0:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       pwm;

  always #2.5 clk = ~clk;

  bitsel_pwm dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata), .pwm_o(pwm)
  );

  typedef struct { logic exp; string tag; } item_t;
  item_t sb_q[$];
  event  sample_ev;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state, built from the requirements
  logic       m_en;
  logic [1:0] m_p;
  logic [6:0] m_duty;
  logic [7:0] m_cnt;
  logic       last_pwm;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // monitor: pops one expected level per tick
  initial forever begin
    @(sample_ev);
    if (sb_q.size() == 0) begin
      chk(1'b0, "scoreboard-empty", 0, 1);
    end else begin
      item_t it;
      it = sb_q.pop_front();
      chk(pwm === it.exp, it.tag, int'(pwm), int'(it.exp));
    end
    last_pwm = pwm;
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 1'b0) begin
      m_en = d[7]; m_p = d[1:0];
      if (!m_en) m_cnt = 8'd0;
    end else begin
      m_duty = d[6:0];
    end
  endtask

  task automatic rd_chk(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    chk(rdata === exp, tag, int'(rdata), int'(exp));
  endtask

  task automatic do_tick(input string tag);
    item_t it;
    logic [7:0] nxt;
    if (m_en) begin
      nxt = m_cnt + 8'd1;
      m_cnt = nxt[7 - m_p] ? 8'd0 : nxt;
    end
    it.exp = m_en && (m_cnt < {1'b0, m_duty});
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    @(negedge clk) -> sample_ev;
    #0.1;
  endtask

  task automatic run(input int n, input string tag, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      do_tick(tag);
      if (last_pwm) highs++;
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int h, len;
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; addr = 1'b0; wdata = 8'h00;
    m_en = 1'b0; m_p = 2'd0; m_duty = 7'd0; m_cnt = 8'd0; last_pwm = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1
    rd_chk(1'b0, 8'h00, "R1 ctrl");
    rd_chk(1'b1, 8'h00, "R1 duty");
    chk(pwm === 1'b0, "R1 pwm", int'(pwm), 0);

    // R10: reserved bits, writes while disabled
    wr(1'b0, 8'h7C); rd_chk(1'b0, 8'h00, "R10 ctrl rsvd");
    wr(1'b1, 8'h80); rd_chk(1'b1, 8'h00, "R10 duty rsvd");
    wr(1'b1, 8'hFF); rd_chk(1'b1, 8'h7F, "R10 duty ff");
    wr(1'b0, 8'hFF); rd_chk(1'b0, 8'h83, "R10 ctrl ff");
    wr(1'b0, 8'h00);

    // R7: disabled with full duty stays low
    run(10, "R7", h);
    chk(h == 0, "R7 highs off", h, 0);

    // R2/R3: each prescaler, fresh start
    for (int p = 0; p < 4; p++) begin
      len = 128 >> p;
      wr(1'b1, 8'(5 + 3 * p));
      wr(1'b0, 8'h80 | 8'(p));
      run(len, "R3", h);
      run(len, "R3", h);
      chk(h == 5 + 3 * p, "R2 highs per period", h, 5 + 3 * p);
      wr(1'b0, 8'h00);
    end

    // R4
    wr(1'b1, 8'h00); wr(1'b0, 8'h81);
    run(70, "R4", h);
    chk(h == 0, "R4 highs", h, 0);
    wr(1'b0, 8'h00);

    // R5
    wr(1'b1, 8'd127); wr(1'b0, 8'h80);
    run(128, "R5", h);
    chk(h == 127, "R5 highs", h, 127);
    wr(1'b0, 8'h00);

    // R6
    wr(1'b1, 8'd40); wr(1'b0, 8'h82);
    run(32, "R6", h);
    chk(h == 32, "R6 p2 highs", h, 32);
    wr(1'b1, 8'd16); wr(1'b0, 8'h83);
    run(16, "R6", h);
    chk(h == 16, "R6 p3 highs", h, 16);
    wr(1'b0, 8'h00);

    // R8: duty change mid-period
    wr(1'b1, 8'd10); wr(1'b0, 8'h82);
    run(5, "R8", h);
    chk(last_pwm === 1'b1, "R8 before", int'(last_pwm), 1);
    wr(1'b1, 8'd3);
    @(negedge clk);
    chk(pwm === 1'b0, "R8 immediate", int'(pwm), 0);
    run(40, "R8", h);
    wr(1'b0, 8'h00);

    // R9: prescaler switch keeps the count
    wr(1'b1, 8'd4); wr(1'b0, 8'h80);
    run(40, "R9", h);
    wr(1'b0, 8'h83);
    run(7, "R9", h);
    chk(h == 0, "R9 no clear on switch", h, 0);
    run(1, "R9", h);
    chk(h == 1, "R9 clear on new bit", h, 1);
    run(16, "R9", h);
    chk(h == 4, "R9 new period highs", h, 4);
    wr(1'b0, 8'h00);

    // R7: re-enable restarts from zero
    wr(1'b1, 8'd2); wr(1'b0, 8'h83);
    run(1, "R7", h);
    chk(h == 1, "R7 restart", h, 1);
    run(1, "R7", h);
    chk(h == 0, "R7 restart end", h, 0);

    chk(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule